// File: doc/BRIEF.md
# Boot Image Signature Checker

This block is a one-shot sequencer that runs right after reset. It decides whether the processor should jump into the user image held in flash or stay in the loader's command path. It works from three inputs. The first is a reset-cause level that tells a hard reset from a soft one, such as a watchdog expiry. The second is an asynchronous boot-request pin. The third is a word-read port into flash.

On a hard reset with the pin held low, the image is not examined and the command path is chosen at once. Otherwise the sequencer reads the eight words of the vector table and adds them with 32-bit wraparound. Slot five of the table is reserved for a check word, which is the two's complement of the sum of the other seven. A table whose words add to zero is therefore treated as valid. A valid image raises the start-user flag, the request to switch the remap mode to flash, and the program-counter-to-zero flag. Any other total selects the command handler.

The result is announced with a single-cycle done pulse and then held until the next reset.

Top module: `boot_sig_checker`

## Requirements
- R1: After a hard reset (`hardReset`=1) with the synchronised pin low, `enterCmd` is raised and `rdReq` never asserts.
- R2: After a soft reset (`hardReset`=0), or a hard reset with the pin high, the sequencer reads the vector table before choosing an outcome.
- R3: The reads request byte addresses 0x00, 0x04, up to 0x1C, in ascending order. `rdReq` and `rdAddr` stay unchanged until `rdAck`. Each `rdAck` consumes `rdData` as one word.
- R4: The eight words are summed in a 32-bit accumulator, and carries out of bit 31 are dropped.
- R5: A zero total raises `startUser`, `remapFlash` and `forcePcZero` together.
- R6: A nonzero total raises `enterCmd`, and none of the three user-image outputs rises.
- R7: Exactly one of `startUser` and `enterCmd` asserts. `bootDone` is high for exactly one cycle, in the same cycle that the outcome first appears. The outcome then stays constant until reset.
- R8: The boot-request pin passes through a two-flop synchroniser. The gate decision is taken at the third rising edge after reset is released, so on the gated path the outcome appears after that edge.
- R9: While `rstN` is low, all outputs are low.
- R10: Changes on `hardReset` or on the pin after the decision edge have no effect on the reads or on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hardReset | input | 1 | Reset cause: 1 = hard reset, 0 = soft reset |
| bootReqPin | input | 1 | Asynchronous boot-request pin; low requests the loader |
| rdReq | output | 1 | Flash word read request |
| rdAddr | output | 32 | Byte address of the requested word |
| rdAck | input | 1 | Read completes; `rdData` is valid |
| rdData | input | 32 | Read data |
| bootDone | output | 1 | One-cycle pulse when the outcome is decided |
| startUser | output | 1 | Start the user image |
| forcePcZero | output | 1 | Program counter is forced to zero |
| remapFlash | output | 1 | Request the flash remap mode |
| enterCmd | output | 1 | Enter the loader command handler |

## Verification
The assertions take three things for granted about the inputs. `rdAck` is raised only while `rdReq` is high. `rdData` is valid in the acknowledge cycle. `hardReset` and the pin are stable from reset until the decision edge. The stimulus keeps to these rules. The flash model answers only a pending request, after a random wait of zero to a few cycles. The reset cause and the pin are set while reset is held, and they are toggled only once the reads are under way.

// File: rtl/bootchk_pkg.sv
package bootchk_pkg;

  typedef enum logic [2:0] {
    ST_SYNC   = 3'd0,
    ST_DECIDE = 3'd1,
    ST_READ   = 3'd2,
    ST_CHECK  = 3'd3,
    ST_DONE   = 3'd4
  } bootState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAcc;
    logic addWord;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic lastWord;
    logic sumZero;
  } dpStat_t;

endpackage

// File: rtl/boot_pin_sync.sv
module boot_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  output logic pinSync
);

  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[0] <= 1'b0;
        else       chain[0] <= pinAsync;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[s] <= 1'b0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign pinSync = chain[STAGES-1];

endmodule

// File: rtl/boot_datapath.sv
module boot_datapath
  import bootchk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int NUM_VEC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output dpStat_t           dpStat
);

  localparam int IDX_W  = $clog2(NUM_VEC);
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int PAD_W  = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rstN || dpCtrl.clearAcc) begin
      wordIdx <= '0;
      acc     <= '0;
    end else if (dpCtrl.addWord) begin
      wordIdx <= wordIdx + 1'b1;
      acc     <= acc + rdData;  // carry out of the top bit is dropped
    end
  end

  assign rdAddr          = {{PAD_W{1'b0}}, wordIdx, {OFF_W{1'b0}}};
  assign dpStat.lastWord = (wordIdx == IDX_W'(NUM_VEC - 1));
  assign dpStat.sumZero  = (acc == '0);

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import bootchk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hardReset,
  input  logic    pinSync,
  input  logic    rdAck,
  input  dpStat_t dpStat,
  output dpCtrl_t dpCtrl,
  output logic    rdReq,
  output logic    bootDone,
  output logic    startUser,
  output logic    forcePcZero,
  output logic    remapFlash,
  output logic    enterCmd
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 1);

  bootState_t        state;
  logic [CNT_W-1:0]  waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_SYNC;
      waitCnt     <= '0;
      bootDone    <= 1'b0;
      startUser   <= 1'b0;
      forcePcZero <= 1'b0;
      remapFlash  <= 1'b0;
      enterCmd    <= 1'b0;
    end else begin
      bootDone <= 1'b0;
      unique case (state)
        ST_SYNC: begin
          if (waitCnt == CNT_W'(SYNC_STAGES - 1)) state <= ST_DECIDE;
          else                                    waitCnt <= waitCnt + 1'b1;
        end
        ST_DECIDE: begin
          if (hardReset && !pinSync) begin
            enterCmd <= 1'b1;
            bootDone <= 1'b1;
            state    <= ST_DONE;
          end else begin
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (rdAck && dpStat.lastWord) state <= ST_CHECK;
        end
        ST_CHECK: begin
          bootDone <= 1'b1;
          state    <= ST_DONE;
          if (dpStat.sumZero) begin
            startUser   <= 1'b1;
            forcePcZero <= 1'b1;
            remapFlash  <= 1'b1;
          end else begin
            enterCmd <= 1'b1;
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  assign rdReq           = (state == ST_READ);
  assign dpCtrl.clearAcc = (state == ST_DECIDE);
  assign dpCtrl.addWord  = (state == ST_READ) && rdAck;

endmodule

// File: rtl/boot_sig_checker.sv
module boot_sig_checker
  import bootchk_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int NUM_VEC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hardReset,
  input  logic              bootReqPin,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              bootDone,
  output logic              startUser,
  output logic              forcePcZero,
  output logic              remapFlash,
  output logic              enterCmd
);

  logic    pinSync;
  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  boot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .pinAsync (bootReqPin),
    .pinSync  (pinSync)
  );

  boot_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hardReset   (hardReset),
    .pinSync     (pinSync),
    .rdAck       (rdAck),
    .dpStat      (dpStat),
    .dpCtrl      (dpCtrl),
    .rdReq       (rdReq),
    .bootDone    (bootDone),
    .startUser   (startUser),
    .forcePcZero (forcePcZero),
    .remapFlash  (remapFlash),
    .enterCmd    (enterCmd)
  );

  boot_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dpCtrl (dpCtrl),
    .rdData (rdData),
    .rdAddr (rdAddr),
    .dpStat (dpStat)
  );

endmodule

// File: rtl/boot_sig_checker_chk.sv
module boot_sig_checker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic              rdAck,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              bootDone,
  input logic              startUser,
  input logic              forcePcZero,
  input logic              remapFlash,
  input logic              enterCmd
);

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startUser, enterCmd}) && (bootDone -> (startUser || enterCmd)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone);

  // R7
  outcome_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startUser || enterCmd) |=>
      $stable({startUser, enterCmd, remapFlash, forcePcZero}));

  // R5
  user_remap_chk: assert property (@(posedge clk) disable iff (!rstN)
    startUser |-> (remapFlash && forcePcZero));

  // R3
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R3
  aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr[1:0] == 2'b00));

  // R1
  no_read_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startUser || enterCmd) |-> !rdReq);

endmodule

bind boot_sig_checker boot_sig_checker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdReq       (rdReq),
  .rdAck       (rdAck),
  .rdAddr      (rdAddr),
  .bootDone    (bootDone),
  .startUser   (startUser),
  .forcePcZero (forcePcZero),
  .remapFlash  (remapFlash),
  .enterCmd    (enterCmd)
);

// File: tb/boot_sig_checker_tb.sv
module boot_sig_checker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hardReset = 1'b0;
  logic        bootReqPin = 1'b1;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [31:0] rdData = '0;
  logic        bootDone, startUser, forcePcZero, remapFlash, enterCmd;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_sig_checker u_dut (
    .clk(clk), .rstN(rstN), .hardReset(hardReset), .bootReqPin(bootReqPin),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .bootDone(bootDone), .startUser(startUser), .forcePcZero(forcePcZero),
    .remapFlash(remapFlash), .enterCmd(enterCmd)
  );

  // flash image
  logic [31:0] mem [8];

  // reference model state: 0 sync, 1 decide, 2 read, 3 check, 4 done
  int          mPhase, mCnt, mIdx, mReads, mSinceRel;
  logic [31:0] mAcc;
  logic        mDone, mUser, mCmd, mSawReq;
  int          delayLeft;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPhase = 0; mCnt = 0; mIdx = 0; mAcc = '0; mReads = 0; mSinceRel = 0;
    mDone = 0; mUser = 0; mCmd = 0; mSawReq = 0;
  endtask

  // compare every output against the model (state after the last edge)
  task automatic compareAll(input string rtag);
    bit expReq;
    expReq = (mPhase == 2);
    if (rdReq) mSawReq = 1;
    chk(rdReq === expReq, (rtag != "") ? rtag : "R3", "rdReq", 32'(rdReq), 32'(expReq));
    if (expReq)
      chk(rdAddr === 32'(mIdx * 4), "R3", "rdAddr", rdAddr, 32'(mIdx * 4));
    chk(bootDone === mDone, (rtag != "") ? rtag : "R7", "bootDone", 32'(bootDone), 32'(mDone));
    chk(startUser === mUser, (rtag != "") ? rtag : "R5", "startUser", 32'(startUser), 32'(mUser));
    chk(remapFlash === mUser, (rtag != "") ? rtag : "R5", "remapFlash", 32'(remapFlash), 32'(mUser));
    chk(forcePcZero === mUser, (rtag != "") ? rtag : "R5", "forcePcZero", 32'(forcePcZero), 32'(mUser));
    chk(enterCmd === mCmd, (rtag != "") ? rtag : "R6", "enterCmd", 32'(enterCmd), 32'(mCmd));
  endtask

  // predict the next edge from the inputs just driven
  task automatic modelStep(input bit hardLvl, input bit pinLvl);
    mDone = 0;
    mSinceRel++;
    case (mPhase)
      0: if (mCnt == 1) mPhase = 1; else mCnt++;
      1: if (hardLvl && !pinLvl) begin mCmd = 1; mDone = 1; mPhase = 4; end
         else begin mPhase = 2; mIdx = 0; mAcc = '0; end
      2: if (rdAck) begin
           mAcc = mAcc + rdData;
           mReads++;
           if (mIdx == 7) mPhase = 3; else mIdx++;
         end
      3: begin
           mDone = 1; mPhase = 4;
           if (mAcc == 0) mUser = 1; else mCmd = 1;
         end
      default: ;
    endcase
  endtask

  // kind: 0 valid random, 1 invalid, 2 valid with heavy wraparound, 3 all zero
  task automatic buildImage(input int kind);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 8; i++) begin
      if (kind == 3)      mem[i] = '0;
      else if (kind == 2) mem[i] = 32'hFFFF_FF00 + 32'(i * 3);
      else                mem[i] = $urandom;
      if (i != 5) s = s + mem[i];
    end
    mem[5] = 32'd0 - s;              // check word in slot five
    if (kind == 1) mem[2] = mem[2] ^ 32'h0000_0100;
  endtask

  task automatic runCase(input string name, input bit hard, input bit pin,
                         input int kind, input int maxDelay, input bit toggle,
                         input bit expUser, input int expReads, input int expDoneAt);
    int doneAt;
    bit hardLvl, pinLvl;
    buildImage(kind);
    @(negedge clk);
    rstN = 0; rdAck = 0; rdData = '0;
    hardReset = hard; bootReqPin = pin;
    hardLvl = hard; pinLvl = pin;
    modelReset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      compareAll("R9");                       // R9 reset state
    end
    delayLeft = $urandom % (maxDelay + 1);
    doneAt = -1;
    rstN = 1;
    modelStep(hardLvl, pinLvl);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      compareAll("");
      if (mDone && doneAt < 0) doneAt = mSinceRel;
      if (mPhase == 4 && mSinceRel > doneAt + 4) break;
      // R10 late toggles of reset cause and pin during the reads
      if (toggle && mPhase == 2) begin
        hardReset = ~hardReset; bootReqPin = ~bootReqPin;
      end
      rdAck = 0;
      if (rdReq) begin
        if (delayLeft == 0) begin
          rdAck = 1;
          rdData = mem[rdAddr[4:2]];
          delayLeft = $urandom % (maxDelay + 1);
        end else begin
          delayLeft--;
          rdData = $urandom;
        end
      end
      modelStep(hardLvl, pinLvl);
    end
    rdAck = 0;
    // scenario-level checks
    chk(mReads == expReads, "R2", {name, " reads"}, 32'(mReads), 32'(expReads));
    chk(startUser === expUser, expUser ? "R5" : "R6", {name, " outcome"},
        32'(startUser), 32'(expUser));
    chk(enterCmd === !expUser, "R7", {name, " cmd"}, 32'(enterCmd), 32'(!expUser));
    if (expReads == 0)
      chk(mSawReq == 0, "R1", {name, " no read"}, 32'(mSawReq), 32'd0);
    if (expDoneAt > 0)
      chk(doneAt == expDoneAt, "R8", {name, " decision edge"}, 32'(doneAt), 32'(expDoneAt));
  endtask

  initial begin
    // R1 R8 hard reset, pin low: gated at third edge
    runCase("gate", 1, 0, 0, 0, 0, 0, 0, 3);
    // R2 hard reset, pin high, valid image
    runCase("hardValid", 1, 1, 0, 0, 0, 1, 8, 0);
    // R2 soft reset ignores low pin
    runCase("softLowPin", 0, 0, 0, 2, 0, 1, 8, 0);
    // R6 corrupted word
    runCase("invalid", 0, 1, 1, 1, 0, 0, 8, 0);
    // R6 hard reset pin high invalid
    runCase("hardInvalid", 1, 1, 1, 0, 0, 0, 8, 0);
    // R4 heavy carries out of bit 31
    runCase("wrap", 0, 1, 2, 0, 0, 1, 8, 0);
    // R5 all-zero table is valid
    runCase("zeros", 1, 1, 3, 0, 0, 1, 8, 0);
    // R3 long handshake waits
    runCase("slowAck", 0, 1, 0, 3, 0, 1, 8, 0);
    // R10 toggles after the decision
    runCase("toggle", 1, 1, 0, 1, 1, 1, 8, 0);
    // R10 toggles on an invalid image
    runCase("toggleBad", 0, 0, 1, 2, 1, 0, 8, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule